// File: doc/BRIEF.md
# Edge-Sampled Output Diagnostic Capture

This block records the health of a bank of low-side output drivers at two instants of every PWM period. When the driver is about to switch on, a per-channel strobe freezes the flyback comparator. When the driver is about to switch off, a second strobe freezes the off-state comparator and the current-limit comparator. Each stored value is kept until the same kind of strobe fires again. The serial shifter can therefore read a stable picture of the last complete period, whatever the comparators are doing at the moment of the read.

The stored flags form a fixed-layout status word. The word also carries:
- the registered levels of two external reset-request inputs;
- a thermal flag with hysteresis, built from a trip input and a release input;
- a constant framing bit.

The block also gates the per-channel drive commands. While the undervoltage flag is high, every drive enable is held off. Undervoltage does not disturb any stored diagnostic state. Only an active reset-request input clears the channel latches.

Top module: `edge_diag_capture`

## Requirements
- R1: After the system reset is released, with no strobes, both reset-request inputs high and no thermal event, the status word reads 16'hFF00 and every drive enable is 0. In this state the flyback and off-state flags are 0, the current flags are 1, the thermal flag is 1, the reset-level bits are 1 and the framing bit is 1.
- R2: A rising strobe on channel k stores that channel's flyback comparator into status bit 2k. The new value is visible one clock after the strobe edge.
- R3: A falling strobe on channel k stores two values, visible one clock after the strobe edge:
  - the off-state comparator into status bit 2k+1;
  - the current-limit comparator into status bit 11+k, where 1 means current below the limit and 0 means overcurrent.
- R4: Between strobes, a change on a comparator has no effect on its stored status bit.
- R5: Status bits 8 and 9 show the levels of reset-request inputs A and B, delayed by one clock.
- R6: The thermal flag works as follows:
  - a trip input clears status bit 10 on the next clock, and trip wins when trip and release are high together;
  - a release input, with trip low, sets status bit 10;
  - with both inputs low, the flag holds.
- R7: Status bit 15 is always 1.
- R8: While the undervoltage flag is high, every drive enable is 0 from the next clock on. Undervoltage leaves the stored status unchanged.
- R9: A low level on either reset-request input clears all channel latches on the next clock: the flyback and off-state flags go to 0 and the current flags go to 1. Strobes in the same cycle are overridden, and the thermal flag is not affected.
- R10: Without undervoltage, each drive enable equals the channel's PWM command delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pwm_level | input | 4 | PWM command per channel |
| rise_stb | input | 4 | One-cycle strobe at each channel's PWM rising edge |
| fall_stb | input | 4 | One-cycle strobe at each channel's PWM falling edge |
| cmp_fly | input | 4 | Flyback comparator per channel (1: output below flyback threshold) |
| cmp_off | input | 4 | Off-state comparator per channel (1: output above off-state threshold) |
| cmp_cur | input | 4 | Current-limit comparator per channel (1: below limit) |
| therm_trip | input | 1 | Overtemperature trip |
| therm_release | input | 1 | Temperature below trip point minus hysteresis |
| ext_rst_a | input | 1 | Reset-request input A, active low |
| ext_rst_b | input | 1 | Reset-request input B, active low |
| uv_flag | input | 1 | Undervoltage indication |
| drive_en | output | 4 | Gated drive enable per channel |
| status_word | output | 16 | Assembled status frame |

## Verification
A behavioural reference model is compared against every field of the status word and the drive enables on every clock. The stimulus includes a long stretch of random strobes, comparator levels, thermal events, undervoltage and reset requests. Because comparators and strobes vary independently, this stretch separates a design that samples comparators only at their own strobe from one that tracks them continuously or swaps the rising and falling sources.

Directed patterns then cover the remaining cases:
- inverted comparator levels held between strobes, which shows that the latches hold;
- a one-cycle reset request, which must clear the channel latches but not the thermal flag;
- simultaneous trip and release, which shows the priority of trip;
- an undervoltage window with all commands high, which must hold the enables off without touching the status.

// File: rtl/edge_diag_pkg.sv
package edge_diag_pkg;

   typedef struct packed {
      logic fly;
      logic off;
      logic cur;
   } chan_diag_t;

   localparam chan_diag_t CHAN_CLEAR = '{fly: 1'b0, off: 1'b0, cur: 1'b1};

   function automatic int fly_pos(input int ch);
      return 2 * ch;
   endfunction

   function automatic int off_pos(input int ch);
      return 2 * ch + 1;
   endfunction

   function automatic int cur_pos(input int nch, input int ch);
      return 2 * nch + 3 + ch;
   endfunction

endpackage

// File: rtl/edge_diag_chan.sv
module edge_diag_chan
   import edge_diag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       rise_stb,
   input  logic       fall_stb,
   input  logic       cmp_fly,
   input  logic       cmp_off,
   input  logic       cmp_cur,
   output chan_diag_t diag
);

   chan_diag_t diag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diag_q <= CHAN_CLEAR;
      end else if (clr) begin
         diag_q <= CHAN_CLEAR;
      end else begin
         if (rise_stb) begin
            diag_q.fly <= cmp_fly;
         end
         if (fall_stb) begin
            diag_q.off <= cmp_off;
            diag_q.cur <= cmp_cur;
         end
      end
   end

   assign diag = diag_q;

   AST_FLY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_stb && !clr) |=> (diag.fly == $past(cmp_fly))); // R2
   AST_OFF_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_stb && !clr) |=> (diag.off == $past(cmp_off) && diag.cur == $past(cmp_cur))); // R3
   AST_FLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_stb && !clr) |=> $stable(diag.fly)); // R4
   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_stb && !clr) |=> ($stable(diag.off) && $stable(diag.cur))); // R4
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!diag.fly && !diag.off && diag.cur)); // R9

endmodule

// File: rtl/edge_diag_thermal.sv
module edge_diag_thermal (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic release_i,
   output logic flag_ok
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b1;
      end else if (trip) begin
         flag_q <= 1'b0;
      end else if (release_i) begin
         flag_q <= 1'b1;
      end
   end

   assign flag_ok = flag_q;

   AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> !flag_ok); // R6
   AST_THERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip && !release_i) |=> $stable(flag_ok)); // R6
   AST_RELEASE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip && release_i) |=> flag_ok); // R6

endmodule

// File: rtl/edge_diag_pack.sv
module edge_diag_pack
   import edge_diag_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int FRAME_W = 3 * NUM_CH + 4
) (
   input  chan_diag_t [NUM_CH-1:0] diag,
   input  logic                    lvl_a,
   input  logic                    lvl_b,
   input  logic                    therm_ok,
   output logic [FRAME_W-1:0]      word
);

   localparam int RES_A_POS = 2 * NUM_CH;
   localparam int RES_B_POS = 2 * NUM_CH + 1;
   localparam int THERM_POS = 2 * NUM_CH + 2;
   localparam int FRAME_POS = 3 * NUM_CH + 3;

   if (FRAME_W != 3 * NUM_CH + 4) begin : g_bad_width
      $error("frame width must equal 3*NUM_CH+4");
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      assign word[fly_pos(k)]         = diag[k].fly;
      assign word[off_pos(k)]         = diag[k].off;
      assign word[cur_pos(NUM_CH, k)] = diag[k].cur;
   end

   assign word[RES_A_POS] = lvl_a;
   assign word[RES_B_POS] = lvl_b;
   assign word[THERM_POS] = therm_ok;
   assign word[FRAME_POS] = 1'b1;

endmodule

// File: rtl/edge_diag_capture.sv
module edge_diag_capture
   import edge_diag_pkg::*;
#(
   parameter int NUM_CH             = 4,
   parameter int FRAME_W            = 3 * NUM_CH + 4,
   parameter bit EXT_RST_ACTIVE_LOW = 1'b1,
   parameter bit DRIVE_REGISTERED   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  pwm_level,
   input  logic [NUM_CH-1:0]  rise_stb,
   input  logic [NUM_CH-1:0]  fall_stb,
   input  logic [NUM_CH-1:0]  cmp_fly,
   input  logic [NUM_CH-1:0]  cmp_off,
   input  logic [NUM_CH-1:0]  cmp_cur,
   input  logic               therm_trip,
   input  logic               therm_release,
   input  logic               ext_rst_a,
   input  logic               ext_rst_b,
   input  logic               uv_flag,
   output logic [NUM_CH-1:0]  drive_en,
   output logic [FRAME_W-1:0] status_word
);

   if (NUM_CH < 1) begin : g_bad_count
      $error("NUM_CH must be at least 1");
   end

   logic                    lvl_a_q;
   logic                    lvl_b_q;
   logic                    chan_clr;
   logic                    therm_ok;
   chan_diag_t [NUM_CH-1:0] diag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_a_q <= 1'b0;
         lvl_b_q <= 1'b0;
      end else begin
         lvl_a_q <= ext_rst_a;
         lvl_b_q <= ext_rst_b;
      end
   end

   if (EXT_RST_ACTIVE_LOW) begin : g_req_low
      assign chan_clr = !ext_rst_a || !ext_rst_b;
   end else begin : g_req_high
      assign chan_clr = ext_rst_a || ext_rst_b;
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
      edge_diag_chan i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (chan_clr),
         .rise_stb (rise_stb[k]),
         .fall_stb (fall_stb[k]),
         .cmp_fly  (cmp_fly[k]),
         .cmp_off  (cmp_off[k]),
         .cmp_cur  (cmp_cur[k]),
         .diag     (diag[k])
      );
   end

   edge_diag_thermal i_thermal (
      .clk       (clk),
      .rst_n     (rst_n),
      .trip      (therm_trip),
      .release_i (therm_release),
      .flag_ok   (therm_ok)
   );

   edge_diag_pack #(
      .NUM_CH  (NUM_CH),
      .FRAME_W (FRAME_W)
   ) i_pack (
      .diag     (diag),
      .lvl_a    (lvl_a_q),
      .lvl_b    (lvl_b_q),
      .therm_ok (therm_ok),
      .word     (status_word)
   );

   if (DRIVE_REGISTERED) begin : g_drv_reg
      logic [NUM_CH-1:0] drv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            drv_q <= '0;
         end else if (uv_flag) begin
            drv_q <= '0;
         end else begin
            drv_q <= pwm_level;
         end
      end
      assign drive_en = drv_q;

      AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         uv_flag |=> (drive_en == '0)); // R8
      AST_DRV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         !uv_flag |=> (drive_en == $past(pwm_level))); // R10
   end else begin : g_drv_comb
      assign drive_en = uv_flag ? '0 : pwm_level;
   end

   AST_LVL_A_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_word[2*NUM_CH] == $past(ext_rst_a))); // R5
   AST_LVL_B_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_word[2*NUM_CH+1] == $past(ext_rst_b))); // R5

endmodule

// File: tb/test_edge_diag_capture.sv
module test_edge_diag_capture;

   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pwm_level = '0, rise_stb = '0, fall_stb = '0;
   logic [N-1:0]  cmp_fly = '0, cmp_off = '0, cmp_cur = '1;
   logic          therm_trip = 1'b0, therm_release = 1'b0;
   logic          ext_rst_a = 1'b1, ext_rst_b = 1'b1, uv_flag = 1'b0;
   logic [N-1:0]  drive_en;
   logic [15:0]   status_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   edge_diag_capture i_edge_diag_capture (
      .clk(clk), .rst_n(rst_n), .pwm_level(pwm_level), .rise_stb(rise_stb),
      .fall_stb(fall_stb), .cmp_fly(cmp_fly), .cmp_off(cmp_off), .cmp_cur(cmp_cur),
      .therm_trip(therm_trip), .therm_release(therm_release),
      .ext_rst_a(ext_rst_a), .ext_rst_b(ext_rst_b), .uv_flag(uv_flag),
      .drive_en(drive_en), .status_word(status_word)
   );

   // behavioural reference state
   bit m_fly[N], m_off[N], m_cur[N];
   bit m_therm, m_la, m_lb;
   bit [N-1:0] m_drv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin m_fly[k] = 0; m_off[k] = 0; m_cur[k] = 1; end
         m_therm = 1; m_la = 0; m_lb = 0; m_drv = '0;
      end else begin
         for (int k = 0; k < N; k++) begin
            if (!ext_rst_a || !ext_rst_b) begin
               m_fly[k] = 0; m_off[k] = 0; m_cur[k] = 1;
            end else begin
               if (rise_stb[k]) m_fly[k] = cmp_fly[k];
               if (fall_stb[k]) begin m_off[k] = cmp_off[k]; m_cur[k] = cmp_cur[k]; end
            end
         end
         if (therm_trip) m_therm = 0;
         else if (therm_release) m_therm = 1;
         m_la = ext_rst_a; m_lb = ext_rst_b;
         m_drv = uv_flag ? '0 : pwm_level;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int k = 0; k < N; k++) begin
            chk("R2 flyback flag", int'(status_word[2*k]), int'(m_fly[k]));
            chk("R3 off-state flag", int'(status_word[2*k+1]), int'(m_off[k]));
            chk("R3 current flag", int'(status_word[11+k]), int'(m_cur[k]));
         end
         chk("R5 reset level A", int'(status_word[8]), int'(m_la));
         chk("R5 reset level B", int'(status_word[9]), int'(m_lb));
         chk("R6 thermal flag", int'(status_word[10]), int'(m_therm));
         chk("R7 framing bit", int'(status_word[15]), 1);
         chk("R10 drive enables", int'(drive_en), int'(m_drv));
      end
   end

   task automatic idle();
      rise_stb = '0; fall_stb = '0; therm_trip = 0; therm_release = 0;
      ext_rst_a = 1; ext_rst_b = 1; uv_flag = 0;
   endtask

   logic [15:0] snap;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk("R1 reset status", int'(status_word), 16'hFF00);
      chk("R1 reset drive", int'(drive_en), 0);

      // random phase
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         pwm_level     = N'($urandom);
         rise_stb      = N'($urandom);
         fall_stb      = N'($urandom);
         cmp_fly       = N'($urandom);
         cmp_off       = N'($urandom);
         cmp_cur       = N'($urandom);
         therm_trip    = ($urandom % 16) == 0;
         therm_release = ($urandom % 16) == 0;
         ext_rst_a     = ($urandom % 40) != 0;
         ext_rst_b     = ($urandom % 40) != 0;
         uv_flag       = ($urandom % 8) == 0;
      end

      // R4: latches hold while comparators change
      @(negedge clk); idle();
      cmp_fly = '1; cmp_off = '1; cmp_cur = '0; rise_stb = '1; fall_stb = '1;
      @(negedge clk);
      rise_stb = '0; fall_stb = '0; cmp_fly = '0; cmp_off = '0; cmp_cur = '1;
      repeat (5) @(negedge clk);
      chk("R4 hold fly/off", int'(status_word[7:0]), 8'hFF);
      chk("R4 hold current", int'(status_word[14:11]), 0);

      // R9: reset request clears channels, strobes overridden, thermal kept
      therm_release = 1;
      @(negedge clk);
      therm_release = 0;
      cmp_fly = '1; cmp_off = '1; cmp_cur = '0;
      ext_rst_b = 0; rise_stb = '1; fall_stb = '1;
      @(negedge clk);
      chk("R9 cleared fly/off", int'(status_word[7:0]), 0);
      chk("R9 cleared current", int'(status_word[14:11]), 4'hF);
      chk("R9 thermal kept", int'(status_word[10]), 1);
      chk("R5 level B low", int'(status_word[9]), 0);
      ext_rst_b = 1; rise_stb = '0; fall_stb = '0;

      // R6: trip priority, hold, release
      therm_trip = 1; therm_release = 1;
      @(negedge clk);
      chk("R6 trip wins", int'(status_word[10]), 0);
      therm_trip = 0; therm_release = 0;
      repeat (3) @(negedge clk);
      chk("R6 flag holds", int'(status_word[10]), 0);
      therm_release = 1;
      @(negedge clk);
      chk("R6 release sets", int'(status_word[10]), 1);
      therm_release = 0;

      // R8: undervoltage forces enables off, state unchanged
      @(negedge clk);
      snap = status_word;
      pwm_level = '1; uv_flag = 1;
      repeat (4) @(negedge clk);
      chk("R8 enables off", int'(drive_en), 0);
      chk("R8 status unchanged", int'(status_word), int'(snap));
      uv_flag = 0;
      @(negedge clk);
      chk("R10 enables follow", int'(drive_en), 4'hF);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule